// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level translation structure held in memory. A request names the linear address, whether the access is a write, the current privilege level, a supervisor-override flag, the frame of the directory page, and two mode enables: one turns on 4 MB large pages and the other makes supervisor writes honour read-only entries. The walker fetches the directory entry and, unless that entry maps a large page, the table entry. It checks presence and permissions and either reports a physical address or reports a fault with an error code and the faulting linear address.

On a successful walk the block updates the entries it used through the same memory port: the directory entry gets its accessed flag, and the final entry gets the accessed flag, plus the dirty flag when the access is a write. The memory port carries one transfer at a time; the walker holds a request until the memory acknowledges it. Read data is taken in the acknowledge cycle. There is no caching of results.

The controller is a single state machine. Its states are IDLE (waiting, ready for a request), RD_DIR (directory entry read), RD_TBL (table entry read), WR_DIR (directory accessed-flag update), WR_LEAF (final entry update), DONE (one-cycle success pulse) and FAULT (one-cycle fault pulse). Its transitions are: IDLE to RD_DIR when a request arrives. RD_DIR goes to FAULT on a denied entry, to WR_LEAF on a permitted large page, and otherwise to RD_TBL. RD_TBL goes to FAULT when denied and otherwise to WR_DIR. WR_DIR goes to WR_LEAF. WR_LEAF goes to DONE. DONE and FAULT both go back to IDLE. Each memory state moves on only in the cycle the memory acknowledges.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, and mem_req, done and fault are 0.
- R2: The first read of a walk goes to the address {dir_base_frame, 12'b0} + linear[31:22] * 4.
- R3: An entry whose bit 0 (present) is 0, at either level, ends the walk in a fault. The error code then has bit 0 = 0, and no memory write is issued.
- R4: When large_en is 1 and directory entry bit 7 is 1, the result is {entry[31:22], linear[21:0]} and no second read is made. When large_en is 0, bit 7 is ignored and the entry points to a table.
- R5: The table entry is read from {dir_entry[31:12], 12'b0} + linear[21:12] * 4. A 4 KB result is {table_entry[31:12], linear[11:0]}.
- R6: For a 4 KB page, the effective user flag (bit 2) and write flag (bit 1) are the AND of the directory and table entries. For a large page they come from the directory entry alone.
- R7: An access counts as user-level when req_cpl is 3 and req_override is 0. A user-level access faults when the effective user flag is 0.
- R8: A write faults when the effective write flag is 0 and either the access is user-level or wp_en is 1. A supervisor write with wp_en 0 succeeds.
- R9: On a fault, fault_code is {req_cpl==3, write, present bit of the faulting entry} (bit 2 down to bit 0), and fault_addr is the linear address.
- R10: On success, the directory entry is written back with bit 5 set, and then the final entry is written with bit 5 set and, for a write, bit 6 set. A large page gets a single write to its directory entry.
- R11: A request is accepted only while req_ready is 1 (IDLE). req_valid in any other state has no effect.
- R12: done and fault are never high together, and each is high for exactly one cycle. A memory request keeps its address, direction and data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken only when req_ready) |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 for a write access |
| req_cpl | input | 2 | Current privilege level (3 = user) |
| req_override | input | 1 | Treat a level-3 access as supervisor for the checks |
| dir_base_frame | input | 20 | Frame number of the directory page |
| large_en | input | 1 | Enable 4 MB pages |
| wp_en | input | 1 | Read-only entries also bind supervisor writes |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = write transfer, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Transfer complete; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: translation succeeded |
| phys_addr | output | 32 | Physical address, valid with done |
| fault | output | 1 | One-cycle pulse: translation faulted |
| fault_code | output | 3 | {user privilege, write, present}, valid with fault |
| fault_addr | output | 32 | Linear address that faulted, valid with fault |

## Verification
Directed walks cover the key cases one at a time: a plain supervisor read, missing entries at each level, a large page with the enable on and off, a user flag that is set in one level only, the override, and a read-only supervisor write with write protection off and on. Each case separates one term of the fault rule from the others. Several hundred random walks then mix random entry flags, privilege, direction and mode enables, with random memory latency. Each is compared against a bench model for result, error code, addresses read, write count and the updated entry values. One walk has a second request pushed while busy, to show that it is dropped.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DIR,
        S_RD_TBL,
        S_WR_DIR,
        S_WR_LEAF,
        S_DONE,
        S_FAULT
    } walk_state_t;

    // Entry flag positions, fixed by the table format
    localparam int F_PRESENT  = 0;
    localparam int F_WRITE    = 1;
    localparam int F_USER     = 2;
    localparam int F_ACCESSED = 5;
    localparam int F_DIRTY    = 6;
    localparam int F_LARGE    = 7;

    // log2 of the entry size in bytes
    localparam int ENT_SHIFT  = 2;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFF_W = 12
) (
    input  logic [DIR_W+TBL_W-1:0]       base_frame,
    input  logic [DIR_W+TBL_W+OFF_W-1:0] lin,
    input  logic [DIR_W+TBL_W-1:0]       dir_frame,
    input  logic [DIR_W+TBL_W-1:0]       leaf_frame,
    output logic [DIR_W+TBL_W+OFF_W-1:0] dir_addr,
    output logic [DIR_W+TBL_W+OFF_W-1:0] tbl_addr,
    output logic [DIR_W+TBL_W+OFF_W-1:0] big_phys,
    output logic [DIR_W+TBL_W+OFF_W-1:0] small_phys
);
    import pgwalk_pkg::*;

    localparam int LIN_W = DIR_W + TBL_W + OFF_W;
    localparam int FRM_W = DIR_W + TBL_W;

    logic [LIN_W-1:0] dir_off;
    logic [LIN_W-1:0] tbl_off;

    assign dir_off    = LIN_W'(lin[LIN_W-1 -: DIR_W]) << ENT_SHIFT;
    assign tbl_off    = LIN_W'(lin[OFF_W +: TBL_W]) << ENT_SHIFT;
    assign dir_addr   = {base_frame, {OFF_W{1'b0}}} | dir_off;
    assign tbl_addr   = {dir_frame,  {OFF_W{1'b0}}} | tbl_off;
    assign big_phys   = {leaf_frame[FRM_W-1 -: DIR_W], lin[TBL_W+OFF_W-1:0]};
    assign small_phys = {leaf_frame, lin[OFF_W-1:0]};
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
    input  logic       present,
    input  logic       eff_user_ok,
    input  logic       eff_write_ok,
    input  logic       is_write,
    input  logic       priv3,
    input  logic       override,
    input  logic       wp_on,
    output logic       deny,
    output logic [2:0] err_code
);
    logic user_acc;

    assign user_acc = priv3 & ~override;
    assign deny     = ~present
                    | (user_acc & ~eff_user_ok)
                    | (is_write & ~eff_write_ok & (user_acc | wp_on));
    assign err_code = {priv3, is_write, present};

    // R9: a missing entry always reports present = 0 and is always denied
    always_comb begin
        if (!present) assert_absent_code_R9: assert (deny && !err_code[0]);
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int DIR_W = 10,
    parameter int TBL_W = 10,
    parameter int OFF_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [DIR_W+TBL_W+OFF_W-1:0]   req_lin,
    input  logic                           req_write,
    input  logic [1:0]                     req_cpl,
    input  logic                           req_override,
    input  logic [DIR_W+TBL_W-1:0]         dir_base_frame,
    input  logic                           large_en,
    input  logic                           wp_en,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [DIR_W+TBL_W+OFF_W-1:0]   mem_addr,
    output logic [DIR_W+TBL_W+OFF_W-1:0]   mem_wdata,
    input  logic                           mem_ack,
    input  logic [DIR_W+TBL_W+OFF_W-1:0]   mem_rdata,
    output logic                           done,
    output logic [DIR_W+TBL_W+OFF_W-1:0]   phys_addr,
    output logic                           fault,
    output logic [2:0]                     fault_code,
    output logic [DIR_W+TBL_W+OFF_W-1:0]   fault_addr
);
    import pgwalk_pkg::*;

    localparam int LIN_W = DIR_W + TBL_W + OFF_W;
    localparam int FRM_W = DIR_W + TBL_W;
    localparam logic [LIN_W-1:0] ACC_MASK = LIN_W'(1) << F_ACCESSED;
    localparam logic [LIN_W-1:0] DRT_MASK = LIN_W'(1) << F_DIRTY;

    walk_state_t state, state_nx;

    // Latched request
    logic [LIN_W-1:0] lin_q;
    logic [FRM_W-1:0] base_q;
    logic             wr_q, priv3_q, ovr_q, lpe_q, wp_q;
    // Latched walk data
    logic [LIN_W-1:0] dir_q, tbl_q, phys_q, faddr_q;
    logic             big_q;
    logic [2:0]       fcode_q;

    // Address composition
    logic [LIN_W-1:0] dir_addr, tbl_addr, big_phys, small_phys;

    pgwalk_addr #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)) u_addr (
        .base_frame (base_q),
        .lin        (lin_q),
        .dir_frame  (dir_q[LIN_W-1:OFF_W]),
        .leaf_frame (mem_rdata[LIN_W-1:OFF_W]),
        .dir_addr   (dir_addr),
        .tbl_addr   (tbl_addr),
        .big_phys   (big_phys),
        .small_phys (small_phys)
    );

    // Permission check on the entry arriving this cycle
    logic       rd_big;
    logic       chk_u, chk_w;
    logic       deny;
    logic [2:0] err_code;

    assign rd_big = mem_rdata[F_LARGE] & lpe_q;

    always_comb begin
        if (state == S_RD_TBL) begin
            chk_u = dir_q[F_USER]  & mem_rdata[F_USER];
            chk_w = dir_q[F_WRITE] & mem_rdata[F_WRITE];
        end else if (rd_big) begin
            chk_u = mem_rdata[F_USER];
            chk_w = mem_rdata[F_WRITE];
        end else begin
            // pointer to a table: only presence matters here
            chk_u = 1'b1;
            chk_w = 1'b1;
        end
    end

    pgwalk_perm u_perm (
        .present      (mem_rdata[F_PRESENT]),
        .eff_user_ok  (chk_u),
        .eff_write_ok (chk_w),
        .is_write     (wr_q),
        .priv3        (priv3_q),
        .override     (ovr_q),
        .wp_on        (wp_q),
        .deny         (deny),
        .err_code     (err_code)
    );

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_RD_DIR;
            S_RD_DIR:  if (mem_ack) begin
                           if (deny)        state_nx = S_FAULT;
                           else if (rd_big) state_nx = S_WR_LEAF;
                           else             state_nx = S_RD_TBL;
                       end
            S_RD_TBL:  if (mem_ack) state_nx = deny ? S_FAULT : S_WR_DIR;
            S_WR_DIR:  if (mem_ack) state_nx = S_WR_LEAF;
            S_WR_LEAF: if (mem_ack) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            S_FAULT:   state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Walk data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q   <= '0;
            base_q  <= '0;
            wr_q    <= 1'b0;
            priv3_q <= 1'b0;
            ovr_q   <= 1'b0;
            lpe_q   <= 1'b0;
            wp_q    <= 1'b0;
            dir_q   <= '0;
            tbl_q   <= '0;
            big_q   <= 1'b0;
            phys_q  <= '0;
            faddr_q <= '0;
            fcode_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    lin_q   <= req_lin;
                    base_q  <= dir_base_frame;
                    wr_q    <= req_write;
                    priv3_q <= &req_cpl;
                    ovr_q   <= req_override;
                    lpe_q   <= large_en;
                    wp_q    <= wp_en;
                end
                S_RD_DIR: if (mem_ack) begin
                    dir_q <= mem_rdata;
                    big_q <= rd_big;
                    if (deny) begin
                        fcode_q <= err_code;
                        faddr_q <= lin_q;
                    end else if (rd_big) begin
                        phys_q <= big_phys;
                    end
                end
                S_RD_TBL: if (mem_ack) begin
                    tbl_q <= mem_rdata;
                    if (deny) begin
                        fcode_q <= err_code;
                        faddr_q <= lin_q;
                    end else begin
                        phys_q <= small_phys;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = '0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state)
            S_IDLE:    req_ready = 1'b1;
            S_RD_DIR:  begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            S_RD_TBL:  begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            S_WR_DIR:  begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dir_q | ACC_MASK;
            end
            S_WR_LEAF: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = big_q ? dir_addr : tbl_addr;
                mem_wdata = (big_q ? dir_q : tbl_q) | ACC_MASK
                          | (wr_q ? DRT_MASK : '0);
            end
            S_DONE:    done  = 1'b1;
            S_FAULT:   fault = 1'b1;
            default:   ;
        endcase
    end

    assign phys_addr  = phys_q;
    assign fault_code = fcode_q;
    assign fault_addr = faddr_q;

    // Checks
    assert_excl_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    assert_done_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_fault_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));
    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
    assert_fault_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !$past(mem_we));
    assert_done_after_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we && mem_ack));
endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
    localparam logic [19:0] BASE = 20'h00100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = 2'd0;
    logic        req_override = 1'b0;
    logic [19:0] dir_base_frame = BASE;
    logic        large_en = 1'b0;
    logic        wp_en = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault;
    logic [31:0] phys_addr, fault_addr;
    logic [2:0]  fault_code;

    always #2 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lin(req_lin), .req_write(req_write), .req_cpl(req_cpl),
        .req_override(req_override), .dir_base_frame(dir_base_frame),
        .large_en(large_en), .wp_en(wp_en), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .phys_addr(phys_addr),
        .fault(fault), .fault_code(fault_code), .fault_addr(fault_addr)
    );

    // Memory model
    logic [31:0] mem_model [logic [31:0]];
    int          lat = 0;
    int          rd_count = 0, wr_count = 0;
    logic [31:0] rd_addr0 = '0, rd_addr1 = '0;

    function automatic logic [31:0] mrd(logic [31:0] a);
        return mem_model.exists(a) ? mem_model[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat     <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat     <= int'($urandom_range(0, 2));
        end else if (mem_req) begin
            if (lat == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem_model[mem_addr] = mem_wdata;
                    wr_count = wr_count + 1;
                end else begin
                    mem_rdata <= mrd(mem_addr);
                    if (rd_count == 0) rd_addr0 = mem_addr;
                    if (rd_count == 1) rd_addr1 = mem_addr;
                    rd_count = rd_count + 1;
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] lin, input bit wr, input logic [1:0] cpl,
                            input bit ovr, input bit wp, input bit lpe,
                            input logic [31:0] dent, input logic [31:0] tent,
                            input bit poke, input string tag);
        logic [31:0] daddr, taddr, ex_phys, ex_dent, ex_tent;
        bit          user, big, ex_fault, eu, ew;
        logic [2:0]  ex_code;
        int          ex_rd, ex_wr, cyc;
        daddr = {BASE, 12'h000} + {20'h0, lin[31:22], 2'b00};
        taddr = {dent[31:12], lin[21:12], 2'b00};
        mem_model[daddr] = dent;
        mem_model[taddr] = tent;
        user = (cpl == 2'd3) && !ovr;
        big  = dent[7] && lpe;
        ex_fault = 0; ex_code = '0; ex_phys = '0;
        ex_dent = dent; ex_tent = tent; ex_rd = 1; ex_wr = 0;
        if (!dent[0]) begin
            ex_fault = 1; ex_code = {cpl == 2'd3, wr, 1'b0};
        end else if (big) begin
            if ((user && !dent[2]) || (wr && !dent[1] && (user || wp))) begin
                ex_fault = 1; ex_code = {cpl == 2'd3, wr, 1'b1};
            end else begin
                ex_phys = {dent[31:22], lin[21:0]};
                ex_dent = dent | 32'h20 | (wr ? 32'h40 : 32'h0);
                ex_wr = 1;
            end
        end else begin
            ex_rd = 2;
            eu = dent[2] & tent[2];
            ew = dent[1] & tent[1];
            if (!tent[0]) begin
                ex_fault = 1; ex_code = {cpl == 2'd3, wr, 1'b0};
            end else if ((user && !eu) || (wr && !ew && (user || wp))) begin
                ex_fault = 1; ex_code = {cpl == 2'd3, wr, 1'b1};
            end else begin
                ex_phys = {tent[31:12], lin[11:0]};
                ex_dent = dent | 32'h20;
                ex_tent = tent | 32'h20 | (wr ? 32'h40 : 32'h0);
                ex_wr = 2;
            end
        end
        rd_count = 0; wr_count = 0;
        @(negedge clk);
        check(req_ready === 1'b1, "R11", {tag, " ready before request"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_lin = lin; req_write = wr; req_cpl = cpl;
        req_override = ovr; wp_en = wp; large_en = lpe;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b1; req_lin = ~lin; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!(done || fault) && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 200, "R12", {tag, " walk finished"}, 32'(cyc), 32'd200);
        if (ex_fault) begin
            check(fault === 1'b1 && done === 1'b0, "R3", {tag, " fault raised"},
                  {30'h0, done, fault}, 32'd1);
            check(fault_code === ex_code, "R9", {tag, " fault code"},
                  32'(fault_code), 32'(ex_code));
            check(fault_addr === lin, "R9", {tag, " fault address"}, fault_addr, lin);
        end else begin
            check(done === 1'b1 && fault === 1'b0, "R5", {tag, " done raised"},
                  {30'h0, done, fault}, 32'd2);
            check(phys_addr === ex_phys, big ? "R4" : "R5", {tag, " physical address"},
                  phys_addr, ex_phys);
        end
        @(negedge clk);
        check(done === 1'b0 && fault === 1'b0, "R12", {tag, " single-cycle pulse"},
              {30'h0, done, fault}, 32'd0);
        check(rd_addr0 === daddr, "R2", {tag, " directory read address"}, rd_addr0, daddr);
        check(rd_count == ex_rd, "R4", {tag, " read count"}, 32'(rd_count), 32'(ex_rd));
        if (ex_rd == 2)
            check(rd_addr1 === taddr, "R5", {tag, " table read address"}, rd_addr1, taddr);
        check(wr_count == ex_wr, "R10", {tag, " write count"}, 32'(wr_count), 32'(ex_wr));
        check(mrd(daddr) === ex_dent, "R10", {tag, " directory entry after"}, mrd(daddr), ex_dent);
        if (!big)
            check(mrd(taddr) === ex_tent, "R10", {tag, " table entry after"}, mrd(taddr), ex_tent);
        if (poke) begin
            repeat (6) begin
                @(negedge clk);
                check(!done && !fault && !mem_req, "R11", {tag, " busy request dropped"},
                      {29'h0, mem_req, done, fault}, 32'd0);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lin, dh, th;
        bit          p1, p2;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0 && fault === 1'b0,
              "R1", "reset state", {28'h0, req_ready, mem_req, done, fault}, 32'h8);

        // Directed corners
        run_walk(32'h1234_5678, 0, 2'd0, 0, 0, 0, 32'h0040_0007, 32'hABCD_E007, 0, "R5 plain read");
        run_walk(32'h0040_1000, 1, 2'd0, 0, 0, 0, 32'h0040_0006, 32'h0, 0, "R3 dir absent");
        run_walk(32'h8000_2abc, 1, 2'd3, 0, 0, 0, 32'h0041_0007, 32'h1111_1006, 0, "R3 table absent");
        run_walk(32'h5533_1234, 1, 2'd0, 0, 0, 1, 32'hA940_0087, 32'h0, 0, "R4 large on");
        run_walk(32'h5533_1234, 0, 2'd0, 0, 0, 0, 32'hA940_0087, 32'h7777_7003, 0, "R4 large off");
        run_walk(32'h0C00_3000, 0, 2'd3, 0, 0, 0, 32'h0042_0003, 32'h2222_2007, 0, "R6 dir user clear");
        run_walk(32'h0C00_3000, 0, 2'd3, 0, 0, 0, 32'h0042_0007, 32'h2222_2007, 0, "R6 both user set");
        run_walk(32'h0C40_5000, 0, 2'd3, 1, 0, 0, 32'h0043_0003, 32'h3333_3003, 0, "R7 override");
        run_walk(32'h0C40_5000, 0, 2'd3, 0, 0, 1, 32'h8000_0083, 32'h0, 0, "R7 large user clear");
        run_walk(32'h1000_6010, 1, 2'd0, 0, 0, 0, 32'h0044_0005, 32'h4444_4007, 0, "R8 wp off");
        run_walk(32'h1000_6010, 1, 2'd0, 0, 1, 0, 32'h0044_0005, 32'h4444_4007, 0, "R8 wp on");
        run_walk(32'h1000_6010, 1, 2'd3, 0, 0, 0, 32'h0044_0007, 32'h4444_4005, 0, "R8 user write ro");
        run_walk(32'h2468_ace0, 1, 2'd1, 0, 0, 0, 32'h0045_0007, 32'h5555_5007, 1, "R11 busy poke");

        // Random walks
        for (int i = 0; i < 400; i++) begin
            lin = $urandom;
            dh  = $urandom & 32'hFFFF_F000;
            if (dh[31:12] == BASE) dh = dh ^ 32'h0000_1000;
            th  = $urandom & 32'hFFFF_F000;
            p1  = ($urandom_range(0, 7) != 0);
            p2  = ($urandom_range(0, 7) != 0);
            run_walk(lin, 1'($urandom), 2'($urandom), 1'($urandom_range(0, 3) == 0),
                     1'($urandom), 1'($urandom),
                     dh | (32'($urandom) & 32'hFFE) | 32'(p1),
                     th | (32'($urandom) & 32'hFFE) | 32'(p2), 0, "R6 R7 R8 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule